// File: doc/BRIEF.md
# Virtual Panel Light Bar and Return Word Datapath

This block computes the two values shown on a host-side virtual control panel. The first is a light bar that fills one lamp at a time from its left end to its right end and then empties and starts again. The second is a return word that is derived from a word the host sends in. The return word is either a free-running up or down count, or a bitwise function of the host word.

The host's virtual switches, virtual pushbuttons and input word arrive as parallel words that are already held in registers. The block samples them into its own register stage. Each pushbutton controls one function: one empties the bar, one freezes the bar, and one zeroes the count. Two switches select the return function.

Both the bar and the counter advance only on an internal step tick, which fires once every `STEP_CYCLES` clock cycles.

Top module: `vio_demo_datapath`

## Requirements
- R1: The bar is a left-aligned run of lit lamps, with bit 23 as the left end. Each step lights one more lamp: 0x000000, then 0x800000, then 0xC00000, and so on.
- R2: The bar and the counter change only on a step tick. A tick fires once every `STEP_CYCLES` cycles after reset. Clear actions are the one exception. In the complement and reversal modes the counter keeps its value.
- R3: While button 15 is sampled high, the bar is empty on the next cycle. This clear takes priority over hold.
- R4: While button 14 is sampled high and button 15 is low, the bar keeps its value across step ticks.
- R5: When the bar is full (0xFFFFFF), the next step empties it to 0x000000. The fill then restarts from the left.
- R6: With {sw15,sw14} = 00, the return word shows the counter. The counter rises by 1 on each step and wraps from 0xFFFFFFFF to 0.
- R7: With {sw15,sw14} = 01, the return word shows the counter. The counter falls by 1 on each step and wraps from 0 to 0xFFFFFFFF.
- R8: While button 13 is sampled high, the counter is 0 on the next cycle.
- R9: With {sw15,sw14} = 10, the return word is the bitwise inverse of the sampled host word.
- R10: With {sw15,sw14} = 11, return bit i equals sampled host bit 31-i.
- R11: All controls and the host word pass through one register stage, so an input change is seen one clock later. After reset the bar is 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsw | input | 16 | Virtual switch word |
| vbtn | input | 16 | Virtual pushbutton word |
| host_word | input | 32 | Word sent by the host |
| light_bar | output | 24 | Light bar, bit 23 is the left end |
| ret_word | output | 32 | Return word shown to the host |

## Verification
The bench builds the block with `STEP_CYCLES` = 3. This lets a complete fill of 24 steps plus the wrap to empty (R5) finish within about 75 cycles. It also makes the down-count wrap from 0 to all ones (R7) reachable in a few cycles after a counter clear. With so short a tick period, hold and clear presses overlap many ticks, and the two buttons can also be pressed together to show which wins.

// File: rtl/vio_pkg.sv
package vio_pkg;
  typedef enum logic [1:0] {
    RET_COUNT_UP   = 2'b00,
    RET_COUNT_DOWN = 2'b01,
    RET_INVERT     = 2'b10,
    RET_REVERSE    = 2'b11
  } ret_mode_t;

  localparam int BTN_BAR_CLEAR = 15;
  localparam int BTN_BAR_FREEZE = 14;
  localparam int BTN_COUNT_CLEAR = 13;
  localparam int SW_MODE_LSB = 14;
endpackage

// File: rtl/vio_step_tick.sv
module vio_step_tick #(
  parameter int STEP_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + CW'(1);
  end
endmodule

// File: rtl/vio_fill_bar.sv
module vio_fill_bar #(
  parameter int BAR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic             freeze,
  output logic [BAR_W-1:0] bar
);
  logic full;
  logic [BAR_W-1:0] bar_nxt;

  assign full = &bar;

  always_comb begin
    bar_nxt = bar;
    if (clear) bar_nxt = '0;
    else if (step && !freeze) bar_nxt = full ? '0 : {1'b1, bar[BAR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bar <= '0;
    else bar <= bar_nxt;
  end
endmodule

// File: rtl/vio_ret_unit.sv
module vio_ret_unit
  import vio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              count_clear,
  input  ret_mode_t         mode,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] count,
  output logic [WORD_W-1:0] ret
);
  function automatic logic [WORD_W-1:0] mirror(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] count_next(input logic [WORD_W-1:0] c,
                                                   input ret_mode_t m);
    case (m)
      RET_COUNT_UP:   return c + WORD_W'(1);
      RET_COUNT_DOWN: return c - WORD_W'(1);
      default:        return c;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (count_clear) count <= '0;
    else if (step) count <= count_next(count, mode);
  end

  always_comb begin
    case (mode)
      RET_INVERT:  ret = ~word_in;
      RET_REVERSE: ret = mirror(word_in);
      default:     ret = count;
    endcase
  end
endmodule

// File: rtl/vio_demo_datapath.sv
module vio_demo_datapath
  import vio_pkg::*;
#(
  parameter int STEP_CYCLES = 1000000,
  parameter int BAR_W = 24,
  parameter int WORD_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] vsw,
  input  logic [CTRL_W-1:0] vbtn,
  input  logic [WORD_W-1:0] host_word,
  output logic [BAR_W-1:0]  light_bar,
  output logic [WORD_W-1:0] ret_word
);
  logic [CTRL_W-1:0] sw_q, btn_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      btn_q <= '0;
      word_q <= '0;
    end else begin
      sw_q <= vsw;
      btn_q <= vbtn;
      word_q <= host_word;
    end
  end

  logic step_tick;
  logic bar_clear, bar_freeze, cnt_clear;
  ret_mode_t ret_mode;
  logic [WORD_W-1:0] cnt_value;

  assign bar_clear = btn_q[BTN_BAR_CLEAR];
  assign bar_freeze = btn_q[BTN_BAR_FREEZE];
  assign cnt_clear = btn_q[BTN_COUNT_CLEAR];
  assign ret_mode = ret_mode_t'(sw_q[SW_MODE_LSB +: 2]);

  vio_step_tick #(.STEP_CYCLES(STEP_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(step_tick)
  );

  vio_fill_bar #(.BAR_W(BAR_W)) u_bar (
    .clk(clk), .rst_n(rst_n), .step(step_tick),
    .clear(bar_clear), .freeze(bar_freeze), .bar(light_bar)
  );

  vio_ret_unit #(.WORD_W(WORD_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .step(step_tick), .count_clear(cnt_clear),
    .mode(ret_mode), .word_in(word_q), .count(cnt_value), .ret(ret_word)
  );
endmodule

// File: rtl/vio_demo_datapath_chk.sv
module vio_demo_datapath_chk #(
  parameter int BAR_W = 24,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bar_clear,
  input logic              bar_freeze,
  input logic              cnt_clear,
  input logic [1:0]        mode,
  input logic [BAR_W-1:0]  bar,
  input logic [WORD_W-1:0] cnt
);
  assert_bar_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bar ^ {bar[BAR_W-2:0], 1'b0}) <= 1);

  assert_bar_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bar_clear) |=> $stable(bar));

  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_clear) |=> $stable(cnt));

  assert_bar_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bar_clear |=> (bar == '0));

  assert_bar_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_freeze && !bar_clear) |=> $stable(bar));

  assert_count_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clear && mode == 2'b00) |=> (cnt == $past(cnt) + WORD_W'(1)));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_clear && mode == 2'b01) |=> (cnt == $past(cnt) - WORD_W'(1)));

  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (cnt == '0));
endmodule

bind vio_demo_datapath vio_demo_datapath_chk #(.BAR_W(BAR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(step_tick), .bar_clear(bar_clear),
  .bar_freeze(bar_freeze), .cnt_clear(cnt_clear), .mode(ret_mode),
  .bar(light_bar), .cnt(cnt_value)
);

// File: tb/vio_demo_datapath_tb.sv
module vio_demo_datapath_tb;
  localparam int STEPS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] vsw = '0, vbtn = '0;
  logic [31:0] host_word = '0;
  logic [23:0] light_bar;
  logic [31:0] ret_word;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R11";

  always #2.5 clk = ~clk;

  vio_demo_datapath #(.STEP_CYCLES(STEPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .vsw(vsw), .vbtn(vbtn), .host_word(host_word),
    .light_bar(light_bar), .ret_word(ret_word)
  );

  // behavioural reference
  int m_phase = 0, m_lit = 0;
  logic [31:0] m_cnt = '0, m_word = '0;
  logic [15:0] m_sw = '0, m_btn = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_lit = 0; m_cnt = '0; m_word = '0; m_sw = '0; m_btn = '0;
    end else begin
      bit t;
      t = (m_phase == STEPS - 1);
      m_phase = t ? 0 : m_phase + 1;
      if (m_btn[15]) m_lit = 0;
      else if (t && !m_btn[14]) m_lit = (m_lit == 24) ? 0 : m_lit + 1;
      if (m_btn[13]) m_cnt = '0;
      else if (t && m_sw[15:14] == 2'b00) m_cnt = m_cnt + 32'd1;
      else if (t && m_sw[15:14] == 2'b01) m_cnt = m_cnt - 32'd1;
      m_sw = vsw; m_btn = vbtn; m_word = host_word;
    end
  end

  function automatic logic [23:0] exp_bar(int n);
    logic [23:0] b = '0;
    for (int k = 0; k < n; k++) b = (b >> 1) | 24'h800000;
    return b;
  endfunction

  function automatic logic [31:0] exp_ret();
    logic [31:0] w = m_word, r = '0;
    case (m_sw[15:14])
      2'b10: return ~m_word;
      2'b11: begin
        for (int k = 0; k < 32; k++) begin
          r = (r << 1) | {31'd0, w[0]};
          w = w >> 1;
        end
        return r;
      end
      default: return m_cnt;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (light_bar !== exp_bar(m_lit)) begin
        errors++;
        $display("FAIL %s bar actual %h expected %h", tag, light_bar, exp_bar(m_lit));
      end
      checks++;
      if (ret_word !== exp_ret()) begin
        errors++;
        $display("FAIL %s ret actual %h expected %h", tag, ret_word, exp_ret());
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <= 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    rst_n = 1'b1;
    tag = "R11";
    @(negedge clk);
    checks++;
    if (light_bar !== 24'h0 || ret_word !== 32'h0) begin
      errors++;
      $display("FAIL R11 reset actual %h/%h expected 0/0", light_bar, ret_word);
    end
    tag = "R1"; run(40);
    tag = "R5"; run(50);
    tag = "R6"; run(10);
    tag = "R4"; vbtn[14] = 1'b1; run(20); vbtn[14] = 1'b0; run(9);
    tag = "R3"; vbtn[15] = 1'b1; run(5); vbtn[15] = 1'b0; run(12);
    vbtn[15] = 1'b1; vbtn[14] = 1'b1; run(8); vbtn = '0; run(7);
    tag = "R8"; vbtn[13] = 1'b1; run(4); vbtn[13] = 1'b0;
    tag = "R7"; vsw[15:14] = 2'b01; run(20);
    tag = "R11"; vsw[3:0] = 4'hA; host_word = 32'h0000_0001; run(3);
    tag = "R9"; vsw[15:14] = 2'b10;
    foreach (pat9[k]) begin host_word = pat9[k]; run(3); end
    tag = "R10"; vsw[15:14] = 2'b11;
    foreach (pat10[k]) begin host_word = pat10[k]; run(3); end
    tag = "R2"; vsw[15:14] = 2'b00; run(12);
    vsw[15:14] = 2'b10; run(10); vsw[15:14] = 2'b00; run(10);
    tag = "R6"; vbtn[13] = 1'b1; run(2); vbtn[13] = 1'b0; run(12);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] pat9 [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_3C3C, 32'h1234_5678};
  logic [31:0] pat10 [4] = '{32'h0000_0001, 32'h8000_0000, 32'h1234_5678, 32'h0F0F_0000};
endmodule